// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Controller

This block watches a group of general-purpose input pins and reports every level change on them, rising or falling alike. Each change latches a bit in three status registers: a power-management status register, a system-management status register and a combined event register that gathers all dual-edge events in one place. Two interrupt outputs, a power-management request and a system-management request, are raised from the latched status. A pin contributes to an output only while that pin's dual-edge mode is selected and its matching enable is set.

Per-pin control arrives on input vectors: mode select, polarity, power-management enable and system-management enable. Polarity has no effect on event detection. It only inverts the pin value that is read back. A small register bus reads the pin values and the three status registers, and clears status bits by writing ones. Inputs pass through a two-flop synchroniser. Edges are found by comparing consecutive synchronised samples.

Top module: `gpio_dual_edge_irq`

## Requirements
- R1: After reset every status bit reads 0 and both `pme_o` and `smi_o` are low.
- R2: A low-to-high change on pin i sets bit i of the power-management status (address 1), the system-management status (address 2) and the combined event status (address 3). The bit is still clear after the second rising clock edge that follows the change, and it is set after the third.
- R3: A high-to-low change on pin i sets the same three status bits as a rising change.
- R4: Status bits latch on an edge whatever the mode-select, polarity and enable settings of that pin.
- R5: Writing to address 1, 2 or 3 clears each status bit of that register whose data bit is 1. Bits written with 0 keep their value, and the other status registers are not touched.
- R6: When an edge on pin i and a write-one-to-clear of bit i fall in the same cycle, the bit stays set.
- R7: `pme_o` is high exactly when some pin has its power-management status, power-management enable and mode-select all at 1. `smi_o` is formed the same way from the system-management status and enables.
- R8: Reading address 0 returns in bit i the synchronised level of pin i, XORed with that pin's polarity bit. Read-data bits above the pin count return 0.
- R9: A pin that is already high when reset is released produces no status event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous GPIO input levels |
| mode_i | input | NUM_PINS | Per-pin dual-edge mode select |
| pol_i | input | NUM_PINS | Per-pin read-back inversion |
| pme_en_i | input | NUM_PINS | Per-pin power-management interrupt enable |
| smi_en_i | input | NUM_PINS | Per-pin system-management interrupt enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 pins, 1 PME status, 2 SMI status, 3 combined status |
| wdata_i | input | DATA_W | Write data, ones clear status bits |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| pme_o | output | 1 | Power-management interrupt request |
| smi_o | output | 1 | System-management interrupt request |

## Verification
The bench checks the exact cycle in which status appears after a pin change. A design with one synchroniser stage too many or too few would fail that check. Falling edges and edges on pins with mode and enables off are both exercised. A design that detected only one edge direction, or that gated latching by the enables, would leave status clear. The bench places a clear write on the same cycle as a new edge, which exposes a clear-priority design because the bit drops. It also releases reset with a pin held high, which exposes a design that treats the reset value as a previous sample because it logs a spurious event.

// File: rtl/gde_pkg.sv
package gde_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_STS  = 3;

  typedef enum logic [1:0] {
    REG_PINS = 2'd0,
    REG_PME  = 2'd1,
    REG_SMI  = 2'd2,
    REG_EVT  = 2'd3
  } reg_e;

  // status bank index; address = index + 1
  localparam int unsigned IDX_PME = 0;
  localparam int unsigned IDX_SMI = 1;
  localparam int unsigned IDX_EVT = 2;
endpackage

// File: rtl/gde_sync.sv
module gde_sync #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gde_edge.sv
module gde_edge #(
  parameter int unsigned N        = 6,
  parameter int unsigned WARM_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] edge_o
);
  localparam int unsigned CW = $clog2(WARM_CYC + 1);

  logic [N-1:0]  prev_q;
  logic [CW-1:0] warm_q;
  logic          armed;

  assign armed = (warm_q == CW'(WARM_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) warm_q <= warm_q + 1'b1;
    end
  end

  // suppress events until synchroniser and history hold real samples
  assign edge_o = armed ? (lvl_i ^ prev_q) : '0;
endmodule

// File: rtl/gde_sts.sv
module gde_sts #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | set_i; // set beats clear
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/gpio_dual_edge_irq.sv
module gpio_dual_edge_irq
  import gde_pkg::*;
#(
  parameter int unsigned NUM_PINS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] mode_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] pme_en_i,
  input  logic [NUM_PINS-1:0] smi_en_i,
  input  logic                wr_i,
  input  logic [1:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                pme_o,
  output logic                smi_o
);
  logic [NUM_PINS-1:0] lvl_w, edge_w;
  logic [NUM_PINS-1:0] sts_w [N_STS];
  logic [NUM_PINS-1:0] pme_sts_w, smi_sts_w, evt_sts_w;

  gde_sync #(.N(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl_w)
  );

  gde_edge #(.N(NUM_PINS), .WARM_CYC(3)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_w), .edge_o(edge_w)
  );

  for (genvar k = 0; k < N_STS; k++) begin : g_bank
    logic [NUM_PINS-1:0] clr;
    assign clr = (wr_i && addr_i == 2'(k + 1)) ? wdata_i[NUM_PINS-1:0] : '0;
    gde_sts #(.N(NUM_PINS)) u_sts (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(edge_w), .clr_i(clr), .sts_o(sts_w[k])
    );
  end

  assign pme_sts_w = sts_w[IDX_PME];
  assign smi_sts_w = sts_w[IDX_SMI];
  assign evt_sts_w = sts_w[IDX_EVT];

  assign pme_o = |(pme_sts_w & pme_en_i & mode_i);
  assign smi_o = |(smi_sts_w & smi_en_i & mode_i);

  always_comb begin
    rdata_o = '0;
    unique case (reg_e'(addr_i))
      REG_PINS: rdata_o[NUM_PINS-1:0] = lvl_w ^ pol_i;
      REG_PME:  rdata_o[NUM_PINS-1:0] = pme_sts_w;
      REG_SMI:  rdata_o[NUM_PINS-1:0] = smi_sts_w;
      REG_EVT:  rdata_o[NUM_PINS-1:0] = evt_sts_w;
      default:  rdata_o = '0;
    endcase
  end

  if (NUM_PINS < DATA_W) begin : g_pad
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:NUM_PINS];
  end
endmodule

// File: rtl/gde_chk.sv
module gde_chk
  import gde_pkg::*;
#(
  parameter int unsigned N = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N-1:0]      mode_i,
  input logic [N-1:0]      pme_en_i,
  input logic [N-1:0]      smi_en_i,
  input logic              pme_o,
  input logic              smi_o,
  input logic [N-1:0]      edge_w,
  input logic [N-1:0]      pme_sts_w,
  input logic [N-1:0]      evt_sts_w
);
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_sts_w & ~$past(evt_sts_w) & ~$past(edge_w)) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_EVT) |=>
      ((evt_sts_w & $past(wdata_i[N-1:0]) & ~$past(edge_w)) == '0)); // R5

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w != '0) |=> ((pme_sts_w & $past(edge_w)) == $past(edge_w))); // R6

  AST_PME_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pme_en_i & mode_i) == '0) |-> !pme_o); // R7

  AST_SMI_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((smi_en_i & mode_i) == '0) |-> !smi_o); // R7
endmodule

bind gpio_dual_edge_irq gde_chk #(.N(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .mode_i(mode_i), .pme_en_i(pme_en_i), .smi_en_i(smi_en_i),
  .pme_o(pme_o), .smi_o(smi_o), .edge_w(edge_w),
  .pme_sts_w(pme_sts_w), .evt_sts_w(evt_sts_w)
);

// File: tb/sim_gpio_dual_edge_irq.sv
module sim_gpio_dual_edge_irq;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0, mode = '0, pol = '0, pme_en = '0, smi_en = '0;
  logic          wr = 1'b0;
  logic [1:0]    addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          pme, smi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_dual_edge_irq #(.NUM_PINS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .mode_i(mode), .pol_i(pol),
    .pme_en_i(pme_en), .smi_en_i(smi_en), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pme_o(pme), .smi_o(smi)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr1c(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic clear_all();
    for (int a = 1; a < 4; a++) wr1c(2'(a), 8'hFF);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 1; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 status after reset", d, 8'h00);
    end
    check("R1 pme_o after reset", {7'b0, pme}, 8'h00);
    check("R1 smi_o after reset", {7'b0, smi}, 8'h00);
  endtask

  task automatic t_rise_latency();
    logic [7:0] d;
    @(negedge clk);
    pin[0] = 1'b1; addr = 2'd3;
    @(negedge clk); @(negedge clk);
    #1 check("R2 not yet set after two edges", rdata, 8'h00);
    @(negedge clk);
    #1 check("R2 event bit after three edges", rdata, 8'h01);
    rd(2'd1, d); check("R2 pme status", d, 8'h01);
    rd(2'd2, d); check("R2 smi status", d, 8'h01);
    clear_all();
  endtask

  task automatic t_fall();
    logic [7:0] d;
    @(negedge clk);
    pin[0] = 1'b0;
    settle();
    rd(2'd3, d); check("R3 falling edge event", d, 8'h01);
    rd(2'd1, d); check("R3 falling edge pme", d, 8'h01);
    clear_all();
  endtask

  task automatic t_ignored_ctrl();
    logic [7:0] d;
    @(negedge clk);
    mode = '0; pme_en = '0; smi_en = '0; pol = 6'b001000;
    pin[3] = 1'b1;
    settle();
    rd(2'd1, d); check("R4 pme latches with mode/enables off", d, 8'h08);
    rd(2'd2, d); check("R4 smi latches with mode/enables off", d, 8'h08);
    rd(2'd3, d); check("R4 event latches with polarity set", d, 8'h08);
    check("R7 no pme_o with mode off", {7'b0, pme}, 8'h00);
    @(negedge clk); pol = '0; pin[3] = 1'b0;
    settle();
    clear_all();
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    @(negedge clk);
    pin[2] = 1'b1; pin[4] = 1'b1;
    settle();
    wr1c(2'd1, 8'h04);
    rd(2'd1, d); check("R5 pme bit2 cleared, bit4 kept", d, 8'h10);
    rd(2'd2, d); check("R5 smi untouched by pme clear", d, 8'h14);
    rd(2'd3, d); check("R5 event untouched by pme clear", d, 8'h14);
    wr1c(2'd3, 8'h00);
    rd(2'd3, d); check("R5 zero write keeps bits", d, 8'h14);
    @(negedge clk); pin[2] = 1'b0; pin[4] = 1'b0;
    settle();
    clear_all();
  endtask

  task automatic t_edge_wins();
    logic [7:0] d;
    @(negedge clk);
    pin[0] = 1'b1; pin[1] = 1'b1;
    settle();
    @(negedge clk);
    pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 2'd3; wdata = 8'h03;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    rd(2'd3, d); check("R6 edge beats same-cycle clear", d, 8'h02);
    @(negedge clk); pin[0] = 1'b0;
    settle();
    clear_all();
  endtask

  task automatic t_irq();
    @(negedge clk);
    mode = 6'b000001; pme_en = 6'b000001; smi_en = '0;
    pin[0] = 1'b1;
    settle();
    check("R7 pme_o raised", {7'b0, pme}, 8'h01);
    check("R7 smi_o stays low without enable", {7'b0, smi}, 8'h00);
    @(negedge clk); smi_en = 6'b000001;
    #1 check("R7 smi_o follows enable", {7'b0, smi}, 8'h01);
    @(negedge clk); mode = '0;
    #1 check("R7 mode off masks pme_o", {7'b0, pme}, 8'h00);
    @(negedge clk); mode = 6'b000001;
    wr1c(2'd1, 8'h01);
    #1 check("R7 pme_o drops after clear", {7'b0, pme}, 8'h00);
    check("R7 smi_o still set", {7'b0, smi}, 8'h01);
    @(negedge clk); pin[0] = 1'b0; mode = '0; pme_en = '0; smi_en = '0;
    settle();
    clear_all();
  endtask

  task automatic t_pins();
    logic [7:0] d;
    @(negedge clk);
    pin = 6'b100100; pol = 6'b000110;
    settle();
    rd(2'd0, d); check("R8 pin read with polarity", d, 8'h22);
    @(negedge clk); pin = '0; pol = '0;
    settle();
    clear_all();
  endtask

  task automatic t_init_high();
    logic [7:0] d;
    pin[5] = 1'b1;
    do_reset();
    settle();
    rd(2'd3, d); check("R9 no event for initial level", d, 8'h00);
    rd(2'd0, d); check("R9 initial level visible", d, 8'h20);
    @(negedge clk); pin[5] = 1'b0;
    settle();
    rd(2'd3, d); check("R9 later edge still seen", d, 8'h20);
    clear_all();
  endtask

  initial begin
    do_reset();
    t_reset();
    t_rise_latency();
    t_fall();
    t_ignored_ctrl();
    t_w1c();
    t_edge_wins();
    t_irq();
    t_pins();
    t_init_high();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule